// File: doc/BRIEF.md
# Up/Down Timer with Forced Events and Capture/Compare Channels

This block is a general-purpose counting timer. A prescaler divides the clock by a programmed ratio, and a main counter steps once per prescaler wrap. The counter counts up, counts down, or runs center-aligned (up, then down) between zero and an auto-reload limit. The prescaler ratio and the auto-reload limit are written to preload registers. They move into the active copies only on an update event, which is either a natural wrap of the counter or an update forced by software.

Each channel is set to compare (output) or capture (input) by a 2-bit select field. Software can force a per-channel event through a self-clearing event register. The effect depends on the channel direction:
- On an output channel, the event only raises the channel flag.
- On an input channel, the event captures the counter value.

A rising edge on a channel pin captures the counter in the same way. An output channel also flags when the counter steps onto its compare value.

Software clears flags by writing 0 to the flag bits. Requests are flags gated by per-source enables.

Registers are written through a single-cycle write strobe and read through a combinational read port. Neither port has a handshake, because every access completes in one cycle. Word addresses:

| Address | Contents |
|---|---|
| 0 | control: bit0 run, bit1 down, bit2 center-aligned |
| 1 | prescaler preload |
| 2 | auto-reload preload |
| 3 | channel selects, two bits per channel |
| 4 | request enables |
| 5 | status flags |
| 6 | event generation |
| 7 | counter, read-only |
| 8+i | compare/capture register of channel i |

Top module: `tmr_evgen`

## Requirements
- R1: Event register (address 6) bit0 forces an update and bit 1+i forces an event on channel i. The event acts on the clock edge after the write, and the register then reads 0. Writing 0 to it does nothing.
- R2: A forced update sets the counter to 0 when counting up (control bit1=0) or in center-aligned mode (control bit2=1). In down edge-aligned mode it sets the counter to the auto-reload preload value.
- R3: A forced update clears the prescaler's internal count. The ratio is kept, and the preload value becomes active.
- R4: Prescaler and auto-reload writes (addresses 1 and 2) take effect only at the next update event, natural or forced.
- R5: With prescaler ratio P, the counter steps once every P+1 clocks while the run bit is set. Up mode: 0..ARR, then back to 0. Down mode: ARR..0, then reload from the preload. Center mode: up to ARR, then down to 0, with an update at both turns. With run clear, the counter holds.
- R6: Status bit0 is set by every update event, natural or forced. The update request is that bit ANDed with enable bit0.
- R7: A forced event on an output channel sets only status bit 1+i. The counter and the compare register are left unchanged. The channel request is that flag ANDed with enable bit 1+i.
- R8: On an input channel, a forced event or a synchronized rising edge on cap_in[i] copies the counter into register 8+i and sets status bit 1+i.
- R9: An input capture taken while status bit 1+i is already set also sets overcapture bit 1+NUM_CH+i.
- R10: On an output channel, the flag sets in the same cycle that the counter steps onto the compare value.
- R11: Writing 0 to a status bit clears it, and writing 1 has no effect. A set event in the same cycle wins over the clear.
- R12: A channel select of 00 means output. Any other value (01, 10, 11) means input. Writes to register 8+i are ignored while channel i is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 4 | write word address |
| wr_data | input | DATA_W | write data |
| rd_addr | input | 4 | read word address |
| rd_data | output | DATA_W | read data, combinational |
| cap_in | input | NUM_CH | channel capture pins |
| cnt_o | output | CNT_W | current counter value |
| upd_flag_o | output | 1 | update flag |
| upd_req_o | output | 1 | update request |
| cc_flag_o | output | NUM_CH | per-channel flags |
| cc_ovf_o | output | NUM_CH | per-channel overcapture flags |
| cc_req_o | output | NUM_CH | per-channel requests |

## Verification
The bench builds the block with CNT_W=6, NUM_CH=2 and DATA_W=16. The narrow counter keeps whole counting periods short. This lets the bench sweep all three count modes over every auto-reload value from 1 to 5 and every prescaler ratio from 0 to 2, and compare each cycle against an arithmetic model. The model also tracks the expected update and compare flags. Both channels cover the input and output directions, and all four select encodings appear. Directed sequences put a forced update in the middle of a prescaler period and change the auto-reload value while the counter runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PSC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_ARR   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CHSEL = 4'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_EVG   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd7;
  localparam logic [ADDR_W-1:0] A_CCR0  = 4'd8;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2
  } count_mode_e;

  typedef struct packed {
    logic cms;
    logic dir;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         force_upd,
  input  logic         reload,
  input  logic [W-1:0] psc_pre,
  output logic         tick
);
  logic [W-1:0] pcnt_q;
  logic [W-1:0] ratio_q;

  // a tick is issued on the clock that closes one prescaler period
  assign tick = run && (pcnt_q == ratio_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      ratio_q <= '0;
    end else if (force_upd) begin
      pcnt_q  <= '0;
      ratio_q <= psc_pre;
    end else begin
      if (run) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
      if (reload) ratio_q <= psc_pre;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         force_upd,
  input  count_mode_e  mode,
  input  logic [W-1:0] arr_pre,
  output logic [W-1:0] cnt,
  output logic [W-1:0] arr_act,
  output logic         step,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         rising_q;
  logic         nxt_rising;
  logic         wrap;
  logic [W:0]   inc;

  assign inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};

  always_comb begin
    cnt_nxt    = cnt;
    wrap       = 1'b0;
    nxt_rising = rising_q;
    case (mode)
      MODE_DOWN: begin
        if (cnt == '0) begin
          cnt_nxt = arr_pre;
          wrap    = 1'b1;
        end else begin
          cnt_nxt = cnt - ONE;
        end
      end
      MODE_CENTER: begin
        if (rising_q) begin
          if (inc >= {1'b0, arr_act}) begin
            cnt_nxt    = arr_act;
            wrap       = 1'b1;
            nxt_rising = 1'b0;
          end else begin
            cnt_nxt = inc[W-1:0];
          end
        end else begin
          if (cnt <= ONE) begin
            cnt_nxt    = '0;
            wrap       = 1'b1;
            nxt_rising = 1'b1;
          end else begin
            cnt_nxt = cnt - ONE;
          end
        end
      end
      default: begin
        if (cnt >= arr_act) begin
          cnt_nxt = '0;
          wrap    = 1'b1;
        end else begin
          cnt_nxt = inc[W-1:0];
        end
      end
    endcase
  end

  // a forced update overrides a prescaler tick in the same cycle
  assign step     = tick && !force_upd;
  assign wrap_evt = step && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      arr_act  <= '1;
      rising_q <= 1'b1;
    end else if (force_upd) begin
      cnt      <= (mode == MODE_DOWN) ? arr_pre : '0;
      arr_act  <= arr_pre;
      rising_q <= 1'b1;
    end else if (step) begin
      cnt      <= cnt_nxt;
      rising_q <= nxt_rising;
      if (wrap) arr_act <= arr_pre;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         is_input,
  input  logic         cap_pin,
  input  logic         force_ev,
  input  logic [W-1:0] cnt,
  input  logic         step,
  input  logic [W-1:0] cnt_nxt,
  input  logic         ccr_we,
  input  logic [W-1:0] ccr_wdata,
  input  logic         clr_flag,
  input  logic         clr_ovf,
  output logic [W-1:0] ccr,
  output logic         flag,
  output logic         ovf
);
  logic [2:0] sync_q;
  logic       pin_rise;
  logic       capture;
  logic       cmp_hit;
  logic       set_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], cap_pin};
  end

  assign pin_rise = sync_q[1] && !sync_q[2];
  assign capture  = is_input && (force_ev || pin_rise);
  assign cmp_hit  = !is_input && (force_ev || (step && (cnt_nxt == ccr)));
  assign set_flag = capture || cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr  <= '0;
      flag <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (capture)                   ccr <= cnt;
      else if (ccr_we && !is_input)  ccr <= ccr_wdata;

      if (set_flag)      flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;

      if (capture && flag) ovf <= 1'b1;
      else if (clr_ovf)    ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_evgen.sv
module tmr_evgen
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] cap_in,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_flag_o,
  output logic              upd_req_o,
  output logic [NUM_CH-1:0] cc_flag_o,
  output logic [NUM_CH-1:0] cc_ovf_o,
  output logic [NUM_CH-1:0] cc_req_o
);
  localparam int EV_W  = 1 + NUM_CH;
  localparam int SEL_W = 2 * NUM_CH;
  localparam int ST_W  = 1 + 2 * NUM_CH;

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   psc_pre_q;
  logic [CNT_W-1:0]   arr_pre_q;
  logic [SEL_W-1:0]   chsel_q;
  logic [EV_W-1:0]    ien_q;
  logic [EV_W-1:0]    ev_q;
  logic               uif_q;

  count_mode_e        mode;
  logic               tick;
  logic               step;
  logic               wrap_evt;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_nxt;
  logic [CNT_W-1:0]   arr_act;
  logic [CNT_W-1:0]   ccr_q [NUM_CH];

  logic wr_ctrl, wr_psc, wr_arr, wr_sel, wr_ien, wr_stat, wr_evg;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_psc  = wr_en && (wr_addr == A_PSC);
  assign wr_arr  = wr_en && (wr_addr == A_ARR);
  assign wr_sel  = wr_en && (wr_addr == A_CHSEL);
  assign wr_ien  = wr_en && (wr_addr == A_IEN);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_evg  = wr_en && (wr_addr == A_EVG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      psc_pre_q <= '0;
      arr_pre_q <= '1;
      chsel_q   <= '0;
      ien_q     <= '0;
      ev_q      <= '0;
    end else begin
      if (wr_ctrl) ctrl_q    <= ctrl_t'(wr_data[2:0]);
      if (wr_psc)  psc_pre_q <= wr_data[CNT_W-1:0];
      if (wr_arr)  arr_pre_q <= wr_data[CNT_W-1:0];
      if (wr_sel)  chsel_q   <= wr_data[SEL_W-1:0];
      if (wr_ien)  ien_q     <= wr_data[EV_W-1:0];
      // event bits live for one cycle only
      ev_q <= wr_evg ? wr_data[EV_W-1:0] : '0;
    end
  end

  always_comb begin
    if (ctrl_q.cms)      mode = MODE_CENTER;
    else if (ctrl_q.dir) mode = MODE_DOWN;
    else                 mode = MODE_UP;
  end

  tmr_prescale #(.W(CNT_W)) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .force_upd (ev_q[0]),
    .reload    (wrap_evt),
    .psc_pre   (psc_pre_q),
    .tick      (tick)
  );

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .force_upd (ev_q[0]),
    .mode      (mode),
    .arr_pre   (arr_pre_q),
    .cnt       (cnt),
    .arr_act   (arr_act),
    .step      (step),
    .cnt_nxt   (cnt_nxt),
    .wrap_evt  (wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       uif_q <= 1'b0;
    else if (ev_q[0] || wrap_evt)     uif_q <= 1'b1;
    else if (wr_stat && !wr_data[0])  uif_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic is_in;
    assign is_in = (chsel_q[2*i +: 2] != 2'b00);

    tmr_chan #(.W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_input  (is_in),
      .cap_pin   (cap_in[i]),
      .force_ev  (ev_q[1+i]),
      .cnt       (cnt),
      .step      (step),
      .cnt_nxt   (cnt_nxt),
      .ccr_we    (wr_en && (wr_addr == ADDR_W'(int'(A_CCR0) + i))),
      .ccr_wdata (wr_data[CNT_W-1:0]),
      .clr_flag  (wr_stat && !wr_data[1+i]),
      .clr_ovf   (wr_stat && !wr_data[1+NUM_CH+i]),
      .ccr       (ccr_q[i]),
      .flag      (cc_flag_o[i]),
      .ovf       (cc_ovf_o[i])
    );

    assign cc_req_o[i] = cc_flag_o[i] && ien_q[1+i];
  end

  assign cnt_o      = cnt;
  assign upd_flag_o = uif_q;
  assign upd_req_o  = uif_q && ien_q[0];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = DATA_W'(ctrl_q);
      A_PSC:   rd_data = DATA_W'(psc_pre_q);
      A_ARR:   rd_data = DATA_W'(arr_pre_q);
      A_CHSEL: rd_data = DATA_W'(chsel_q);
      A_IEN:   rd_data = DATA_W'(ien_q);
      A_STAT:  rd_data = DATA_W'({cc_ovf_o, cc_flag_o, uif_q});
      A_EVG:   rd_data = DATA_W'(ev_q);
      A_CNT:   rd_data = DATA_W'(cnt);
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (rd_addr == ADDR_W'(int'(A_CCR0) + i)) rd_data = DATA_W'(ccr_q[i]);
        end
      end
    endcase
  end

  logic [ST_W-1:0] stat_unused;
  assign stat_unused = '0;
endmodule

// File: rtl/tmr_evgen_chk.sv
module tmr_evgen_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              upd_flag_o,
  input logic              upd_req_o,
  input logic [NUM_CH-1:0] cc_flag_o,
  input logic [NUM_CH-1:0] cc_ovf_o,
  input logic [NUM_CH-1:0] cc_req_o,
  input logic [NUM_CH:0]   ev_q,
  input logic [2:0]        ctrl
);
  AST_EVG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_q != '0) && !(wr_en && wr_addr == A_EVG)) |=> (ev_q == '0)); // R1

  AST_UG_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[0] && (ctrl[2] || !ctrl[1])) |=> (cnt_o == '0)); // R2

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ev_q[0]) |=> $stable(cnt_o)); // R5

  AST_UREQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_o |-> upd_flag_o); // R6

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    AST_CREQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cc_req_o[i] |-> cc_flag_o[i]); // R7

    AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cc_ovf_o[i]) |-> $past(cc_flag_o[i])); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_flag_o[i] && !(wr_en && wr_addr == A_STAT)) |=> cc_flag_o[i]); // R11
  end
endmodule

bind tmr_evgen tmr_evgen_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .cnt_o      (cnt_o),
  .upd_flag_o (upd_flag_o),
  .upd_req_o  (upd_req_o),
  .cc_flag_o  (cc_flag_o),
  .cc_ovf_o   (cc_ovf_o),
  .cc_req_o   (cc_req_o),
  .ev_q       (ev_q),
  .ctrl       (ctrl_q)
);

// File: tb/test_tmr_evgen.sv
module test_tmr_evgen;
  import tmr_pkg::*;

  localparam int CW = 6;
  localparam int NC = 2;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NC-1:0] cap_in = '0;
  logic [CW-1:0] cnt_o;
  logic          upd_flag_o, upd_req_o;
  logic [NC-1:0] cc_flag_o, cc_ovf_o, cc_req_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int m_cnt, m_pm, m_psc, m_psc_pre, m_arr, m_arr_pre, m_mode, m_ccr0;
  bit m_up, m_upd, m_cmp;

  always #10 clk = ~clk;

  tmr_evgen #(.CNT_W(CW), .NUM_CH(NC), .DATA_W(DW)) i_tmr_evgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .cnt_o(cnt_o),
    .upd_flag_o(upd_flag_o), .upd_req_o(upd_req_o), .cc_flag_o(cc_flag_o),
    .cc_ovf_o(cc_ovf_o), .cc_req_o(cc_req_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  // write an event and wait until it has acted
  task automatic ev(input int bits);
    wr(A_EVG, bits);
    @(negedge clk);
  endtask

  task m_step();
    bit wrap;
    wrap = 0;
    if (m_pm == m_psc) begin
      m_pm = 0;
      case (m_mode)
        1: if (m_cnt == 0) begin m_cnt = m_arr_pre; wrap = 1; end else m_cnt--;
        2: if (m_up) begin
             if (m_cnt + 1 >= m_arr) begin m_cnt = m_arr; m_up = 0; wrap = 1; end else m_cnt++;
           end else begin
             if (m_cnt <= 1) begin m_cnt = 0; m_up = 1; wrap = 1; end else m_cnt--;
           end
        default: if (m_cnt >= m_arr) begin m_cnt = 0; wrap = 1; end else m_cnt++;
      endcase
      if (wrap) begin m_arr = m_arr_pre; m_psc = m_psc_pre; m_upd = 1; end
      if (m_cnt == m_ccr0) m_cmp = 1;
    end else begin
      m_pm++;
    end
  endtask

  task m_ug();
    m_pm = 0; m_psc = m_psc_pre; m_arr = m_arr_pre; m_up = 1; m_upd = 1;
    m_cnt = (m_mode == 1) ? m_arr_pre : 0;
  endtask

  // configure, force an update, clear flags, then start counting
  task automatic set_cfg(input int mode, input int psc, input int arr);
    int cb;
    cb = (mode == 1) ? 2 : (mode == 2) ? 4 : 0;
    wr(A_CTRL, cb);
    wr(A_PSC, psc);
    wr(A_ARR, arr);
    wr(A_CHSEL, 0);
    wr(A_CCR0, 2);
    ev(1);
    wr(A_STAT, 0);
    m_mode = mode; m_psc_pre = psc; m_arr_pre = arr; m_ccr0 = 2;
    m_ug();
    m_upd = 0; m_cmp = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CTRL; wr_data = DW'(cb | 1);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      m_step();
      check(req, "counter", int'(cnt_o), m_cnt);
    end
  endtask

  // write while the counter runs; the model advances over the write edge
  task automatic wr_run(input logic [3:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    m_step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R5", "reset counter", int'(cnt_o), 0);
    check("R6", "reset update flag", int'(upd_flag_o), 0);
    check("R11", "reset cc flags", int'(cc_flag_o), 0);
    check("R7", "reset requests", int'({cc_req_o, upd_req_o}), 0);
    rd(A_ARR, v); check("R4", "reset auto-reload", v, 63);
    rd(A_EVG, v); check("R1", "reset event reg", v, 0);

    // forced update in down mode loads the auto-reload value
    wr(A_CTRL, 2);
    wr(A_ARR, 9);
    ev(1);
    check("R2", "down UG counter", int'(cnt_o), 9);
    rd(A_EVG, v); check("R1", "event reg self-clear", v, 0);
    check("R6", "forced update flag", int'(upd_flag_o), 1);
    check("R6", "update req masked", int'(upd_req_o), 0);
    wr(A_IEN, 1);
    check("R6", "update req enabled", int'(upd_req_o), 1);
    wr(A_STAT, 16'h1F);
    check("R11", "write 1 keeps flag", int'(upd_flag_o), 1);
    wr(A_STAT, 0);
    check("R11", "write 0 clears flag", int'(upd_flag_o), 0);
    wr(A_IEN, 0);
    ev(0);
    check("R1", "zero event counter", int'(cnt_o), 9);
    check("R1", "zero event flag", int'(upd_flag_o), 0);

    // center mode forced update goes to zero even with down bit set
    wr(A_CTRL, 6);
    ev(1);
    check("R2", "center UG counter", int'(cnt_o), 0);

    // forced event on an output channel
    wr(A_CTRL, 2);
    ev(1);
    wr(A_CHSEL, 0);
    wr(A_CCR0, 5);
    wr(A_STAT, 0);
    ev(2);
    check("R7", "output forced flag", int'(cc_flag_o[0]), 1);
    check("R7", "output forced no ovf", int'(cc_ovf_o[0]), 0);
    check("R7", "output forced counter", int'(cnt_o), 9);
    rd(A_CCR0, v); check("R7", "output compare reg kept", v, 5);
    check("R7", "cc req masked", int'(cc_req_o[0]), 0);
    wr(A_IEN, 2);
    check("R7", "cc req enabled", int'(cc_req_o[0]), 1);
    wr(A_IEN, 0);

    // forced capture on input channel 1 (select 01)
    wr(A_CHSEL, 4'b0100);
    wr(A_STAT, 0);
    ev(4);
    rd(A_CCR0 + 4'd1, v); check("R8", "forced capture value", v, 9);
    check("R8", "forced capture flag", int'(cc_flag_o[1]), 1);
    check("R9", "first capture no ovf", int'(cc_ovf_o[1]), 0);
    ev(4);
    check("R9", "second capture ovf", int'(cc_ovf_o[1]), 1);
    wr(A_CCR0 + 4'd1, 33);
    rd(A_CCR0 + 4'd1, v); check("R12", "input reg write ignored", v, 9);
    wr(A_STAT, 0);
    check("R11", "clear ovf", int'(cc_ovf_o[1]), 0);
    ev(4);
    // event and clear at the same edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_EVG; wr_data = 16'h4;
    @(negedge clk);
    wr_addr = A_STAT; wr_data = 16'h0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11", "set beats clear flag", int'(cc_flag_o[1]), 1);
    check("R11", "set beats clear ovf", int'(cc_ovf_o[1]), 1);

    // pin capture, selects 11 and 10 both input
    wr(A_ARR, 7);
    ev(1);
    wr(A_CHSEL, 4'b1011);
    wr(A_STAT, 0);
    cap_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_CCR0, v); check("R8", "pin capture value", v, 7);
    check("R12", "select 11 is input", int'(cc_flag_o[0]), 1);
    check("R9", "pin first no ovf", int'(cc_ovf_o[0]), 0);
    cap_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    cap_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", "pin second ovf", int'(cc_ovf_o[0]), 1);
    cap_in[0] = 1'b0;
    ev(4);
    rd(A_CCR0 + 4'd1, v); check("R12", "select 10 is input", v, 7);

    // forced update mid prescaler period
    set_cfg(0, 3, 20);
    run(6, "R5");
    wr_run(A_EVG, 1);
    @(negedge clk);
    m_ug();
    check("R2", "running UG counter", int'(cnt_o), 0);
    run(10, "R3");

    // auto-reload change while running waits for the wrap
    set_cfg(0, 0, 3);
    run(2, "R5");
    wr_run(A_ARR, 6);
    m_arr_pre = 6;
    run(14, "R4");

    // sweep all modes over small limits and ratios
    for (int md = 0; md < 3; md++) begin
      for (int a = 1; a <= 5; a++) begin
        for (int p = 0; p <= 2; p++) begin
          set_cfg(md, p, a);
          run(2 * (a + 1) * (p + 1) + 4, "R5");
          check("R6", "natural update flag", int'(upd_flag_o), int'(m_upd));
          check("R10", "compare match flag", int'(cc_flag_o[0]), int'(m_cmp));
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule